// File: doc/BRIEF.md
# Timer Gate Controller

This block decides, on every clock, whether an associated 16-bit timer may advance. It picks one of four gate candidates: an asynchronous external pin, which goes through a synchronizer first, the rollover pulse of an 8-bit free-running timer, the period-match pulse of another timer, or a spare input. An optional inversion is applied next. The result can then pass through a toggle stage, which holds the gate open for one full source period. It can also pass through a single-pulse stage, which arms on a software "go" request, opens on the next rising gate edge and closes itself on the trailing edge.

Software drives plain configuration pins: enable, select, invert, toggle mode and single-pulse mode. It also drives a one-cycle `go_set` strobe. It reads back `go_done` and the live `gate_level`. The timer uses `count_en` as its increment qualifier. `gate_event` marks the end of a single-pulse measurement. All pins are plain control and status lines with no handshake. The timer side samples `count_en` every cycle and cannot stall it.

Top module: `tmr_gate_ctrl`

## Requirements
- R1: `src_sel` picks the gate source. 2'b00 is the external pin, seen through a chain of two flip-flops. 2'b01 is the 8-bit rollover pulse. 2'b10 is the match pulse. 2'b11 is the spare input. The non-pin sources reach `gate_level` in the same cycle.
- R2: With `invert`=1, the selected source is complemented before any later stage.
- R3: `gate_level` always shows the level after the source, polarity and toggle stages, whatever the value of `gate_en`.
- R4: While `gate_en`=0, `count_en` is 1.
- R5: With `toggle_en`=1, the toggle flip-flop flips once for each rising edge of the polarity-stage output. `gate_level` changes in the cycle after that edge and stays put otherwise.
- R6: While `toggle_en`=0, the toggle flip-flop is held at 0, so the stage starts at 0 whenever it is enabled.
- R7: With `single_en`=1, a `go_set` strobe sets `go_done`. Counting starts in the cycle of the next rising edge of `gate_level` and continues while it stays high. `go_done` clears on the cycle after the falling edge.
- R8: When `single_en`=1, `gate_en`=1 and `go_done`=0, `count_en` is 0 until software sets go again.
- R9: With both toggle and single-pulse modes on, exactly one full period of the source is counted.
- R10: While `single_en`=0, `go_done` is held at 0 and `go_set` is ignored.
- R11: `gate_event` is high for exactly one cycle, in the same cycle that `go_done` drops at the end of a measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_pin | input | 1 | External gate pin, asynchronous |
| ovf8_pulse | input | 1 | Rollover pulse of the 8-bit timer |
| match_pulse | input | 1 | Period-match pulse of another timer |
| spare_in | input | 1 | Spare gate source |
| gate_en | input | 1 | Gate enable |
| src_sel | input | 2 | Gate source select |
| invert | input | 1 | Polarity invert |
| toggle_en | input | 1 | Toggle mode |
| single_en | input | 1 | Single-pulse mode |
| go_set | input | 1 | One-cycle strobe that arms a single-pulse measurement |
| go_done | output | 1 | Measurement armed or running |
| gate_level | output | 1 | Live gate level |
| count_en | output | 1 | Timer increment enable |
| gate_event | output | 1 | One-cycle end-of-measurement flag |

## Verification
The results arrive at different latencies:
- `count_en` and `gate_level` follow the non-pin sources in the same cycle.
- They follow the pin two edges later.
- With toggle mode on, they follow one edge after the rising edge of the polarity output.
- `go_done` and `gate_event` change at the edge after the trailing edge that ends a measurement.

The bench drives inputs just after a rising edge and samples all four outputs at the following falling edge. A behavioural model advances its state on each rising edge, so every latency listed above is compared in the cycle where it is due. Directed runs also count `count_en` cycles against the number of source-high cycles and against a known source period.

// File: rtl/tgc_pkg.sv
package tgc_pkg;
  typedef enum logic [1:0] {
    SRC_PIN   = 2'b00,
    SRC_OVF   = 2'b01,
    SRC_MATCH = 2'b10,
    SRC_SPARE = 2'b11
  } gate_src_e;

  localparam int SEL_W = 2;
endpackage

// File: rtl/tgc_source.sv
module tgc_source
  import tgc_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_async,
  input  logic             ovf_pulse,
  input  logic             match_pulse,
  input  logic             spare_in,
  input  logic [SEL_W-1:0] sel,
  input  logic             invert,
  output logic             pol_lvl,
  output logic             pol_rise
);
  localparam int LAST = SYNC_DEPTH - 1;

  logic [SYNC_DEPTH-1:0] sync_q;
  logic                  raw_lvl;
  logic                  pol_prev_q;

  // R1: pin synchronizer chain
  genvar g;
  generate
    for (g = 0; g < SYNC_DEPTH; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= pin_async;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  always_comb begin
    case (gate_src_e'(sel))
      SRC_PIN:   raw_lvl = sync_q[LAST];
      SRC_OVF:   raw_lvl = ovf_pulse;
      SRC_MATCH: raw_lvl = match_pulse;
      default:   raw_lvl = spare_in;
    endcase
  end

  assign pol_lvl = raw_lvl ^ invert;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pol_prev_q <= 1'b0;
    else        pol_prev_q <= pol_lvl;

  assign pol_rise = pol_lvl & ~pol_prev_q;
endmodule

// File: rtl/tgc_toggle.sv
module tgc_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic lvl_in,
  input  logic rise_in,
  output logic t_lvl,
  output logic t_rise,
  output logic t_fall
);
  logic tgl_q;
  logic t_prev_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       tgl_q <= 1'b0;
    else if (!enable) tgl_q <= 1'b0;
    else if (rise_in) tgl_q <= ~tgl_q;

  assign t_lvl = enable ? tgl_q : lvl_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) t_prev_q <= 1'b0;
    else        t_prev_q <= t_lvl;

  assign t_rise = t_lvl & ~t_prev_q;
  assign t_fall = ~t_lvl & t_prev_q;
endmodule

// File: rtl/tgc_single.sv
module tgc_single (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_en,
  input  logic go_set,
  input  logic t_lvl,
  input  logic t_rise,
  input  logic t_fall,
  output logic go_q,
  output logic window,
  output logic event_q
);
  logic open_q;
  logic finish;

  assign finish = open_q & t_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q    <= 1'b0;
      open_q  <= 1'b0;
      event_q <= 1'b0;
    end else begin
      event_q <= mode_en & finish;
      if (!mode_en) begin
        go_q   <= 1'b0;
        open_q <= 1'b0;
      end else if (finish) begin
        go_q   <= 1'b0;
        open_q <= 1'b0;
      end else begin
        if (go_q && t_rise) open_q <= 1'b1;
        if (go_set)         go_q   <= 1'b1;
      end
    end
  end

  assign window = t_lvl & (open_q | (go_q & t_rise));
endmodule

// File: rtl/tmr_gate_ctrl.sv
module tmr_gate_ctrl
  import tgc_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_pin,
  input  logic             ovf8_pulse,
  input  logic             match_pulse,
  input  logic             spare_in,
  input  logic             gate_en,
  input  logic [SEL_W-1:0] src_sel,
  input  logic             invert,
  input  logic             toggle_en,
  input  logic             single_en,
  input  logic             go_set,
  output logic             go_done,
  output logic             gate_level,
  output logic             count_en,
  output logic             gate_event
);
  logic pol_lvl, pol_rise;
  logic t_lvl, t_rise, t_fall;
  logic window;

  tgc_source #(.SYNC_DEPTH(SYNC_DEPTH)) u_src (
    .clk(clk), .rst_n(rst_n), .pin_async(gate_pin), .ovf_pulse(ovf8_pulse),
    .match_pulse(match_pulse), .spare_in(spare_in), .sel(src_sel),
    .invert(invert), .pol_lvl(pol_lvl), .pol_rise(pol_rise)
  );

  tgc_toggle u_tgl (
    .clk(clk), .rst_n(rst_n), .enable(toggle_en), .lvl_in(pol_lvl),
    .rise_in(pol_rise), .t_lvl(t_lvl), .t_rise(t_rise), .t_fall(t_fall)
  );

  tgc_single u_sp (
    .clk(clk), .rst_n(rst_n), .mode_en(single_en), .go_set(go_set),
    .t_lvl(t_lvl), .t_rise(t_rise), .t_fall(t_fall),
    .go_q(go_done), .window(window), .event_q(gate_event)
  );

  assign gate_level = t_lvl;
  assign count_en   = ~gate_en | (single_en ? window : t_lvl);
endmodule

// File: rtl/tmr_gate_ctrl_chk.sv
module tmr_gate_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic gate_en,
  input logic toggle_en,
  input logic single_en,
  input logic pol_rise,
  input logic go_done,
  input logic gate_level,
  input logic count_en,
  input logic gate_event
);
  p_en_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |-> count_en);

  p_tgl_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (toggle_en && $past(toggle_en) && !$past(pol_rise)) |-> $stable(gate_level));

  p_tgl_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (toggle_en && !$past(toggle_en)) |-> !gate_level);

  p_done_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && single_en && !go_done) |-> !count_en);

  p_mode_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !single_en |=> !go_done);

  p_event_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    gate_event |=> !gate_event);

  p_event_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    gate_event |-> (!go_done && $past(go_done)));
endmodule

bind tmr_gate_ctrl tmr_gate_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .toggle_en(toggle_en),
  .single_en(single_en), .pol_rise(pol_rise), .go_done(go_done),
  .gate_level(gate_level), .count_en(count_en), .gate_event(gate_event)
);

// File: tb/tmr_gate_ctrl_bench.sv
module tmr_gate_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gate_pin = 0, ovf8_pulse = 0, match_pulse = 0, spare_in = 0;
  logic gate_en = 0, invert = 0, toggle_en = 0, single_en = 0, go_set = 0;
  logic [1:0] src_sel = 2'b00;
  logic go_done, gate_level, count_en, gate_event;

  int checks = 0, failures = 0;
  int meas_cnt = 0;
  bit meas_on = 0;
  bit cmp_on = 0;
  int ev_cnt = 0;

  always #2.5 clk = ~clk;

  tmr_gate_ctrl u_tmr_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .gate_pin(gate_pin), .ovf8_pulse(ovf8_pulse),
    .match_pulse(match_pulse), .spare_in(spare_in), .gate_en(gate_en),
    .src_sel(src_sel), .invert(invert), .toggle_en(toggle_en),
    .single_en(single_en), .go_set(go_set), .go_done(go_done),
    .gate_level(gate_level), .count_en(count_en), .gate_event(gate_event)
  );

  // behavioural reference state
  bit m_s1, m_s2, m_prev_pol, m_prev_t, m_tg, m_go, m_open, m_ev;

  function automatic bit m_pol();
    bit r;
    case (src_sel)
      2'b00: r = m_s2;
      2'b01: r = ovf8_pulse;
      2'b10: r = match_pulse;
      default: r = spare_in;
    endcase
    return r ^ invert;
  endfunction

  function automatic bit m_t();
    return toggle_en ? m_tg : m_pol();
  endfunction

  function automatic bit m_cnt();
    bit t, rise;
    t = m_t();
    rise = t && !m_prev_t;
    if (!gate_en) return 1'b1;
    if (!single_en) return t;
    return t && (m_open || (m_go && rise));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev_pol = 0; m_prev_t = 0;
      m_tg = 0; m_go = 0; m_open = 0; m_ev = 0;
    end else begin
      bit p, t, rp, rt, ft;
      p = m_pol(); t = m_t();
      rp = p && !m_prev_pol; rt = t && !m_prev_t; ft = !t && m_prev_t;
      m_ev = single_en && m_open && ft;
      if (!single_en) begin m_go = 0; m_open = 0; end
      else if (m_open && ft) begin m_go = 0; m_open = 0; end
      else begin
        if (m_go && rt) m_open = 1;
        if (go_set) m_go = 1;
      end
      if (!toggle_en) m_tg = 0;
      else if (rp) m_tg = !m_tg;
      m_prev_pol = p; m_prev_t = t;
      m_s2 = m_s1; m_s1 = gate_pin;
    end
  end

  task automatic chk(input bit act, input bit exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", what, act, exp, $time);
    end
  endtask

  task automatic chk_int(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(gate_level, m_t(),  "R1/R2/R3/R5/R6 gate_level");
      chk(count_en,   m_cnt(), "R4/R7/R8/R9 count_en");
      chk(go_done,    m_go,   "R7/R10 go_done");
      chk(gate_event, m_ev,   "R11 gate_event");
    end
    if (meas_on && count_en) meas_cnt++;
    if (meas_on && gate_event) ev_cnt++;
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      go_set = 0;
    end
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(3);
    #0.5;
    chk(go_done, 1'b0, "R10 reset go_done");
    chk(gate_event, 1'b0, "R11 reset gate_event");
    chk(count_en, 1'b1, "R4 reset count_en with gate off");
    rst_n = 1;
    step(1);
    cmp_on = 1;

    // R1 pin latency with R3 gate off, R2 invert
    gate_pin = 1; step(1);
    #1 chk(gate_level, 1'b0, "R1 pin after one edge");
    step(1);
    #1 chk(gate_level, 1'b1, "R1 pin after two edges");
    invert = 1; #1 chk(gate_level, 1'b0, "R2 inverted pin");
    invert = 0; gate_pin = 0; step(3);

    // R7 pulse width via spare source
    gate_en = 1; src_sel = 2'b11; single_en = 1;
    step(1); go_set = 1; step(2);
    meas_on = 1; meas_cnt = 0; ev_cnt = 0;
    spare_in = 1; step(7); spare_in = 0; step(3);
    chk_int(meas_cnt, 7, "R7 pulse width count");
    chk_int(ev_cnt, 1, "R11 one event per measurement");
    #1 chk(go_done, 1'b0, "R7 go_done cleared after trailing edge");
    // R8 second pulse without re-arm
    meas_cnt = 0;
    spare_in = 1; step(5); spare_in = 0; step(2);
    chk_int(meas_cnt, 0, "R8 no count after done");
    // R10 go_set ignored without mode
    single_en = 0; step(1); go_set = 1; step(2);
    #1 chk(go_done, 1'b0, "R10 go_set ignored with mode off");
    // R9 full period: match pulse every 9 cycles with toggle + single
    single_en = 1; toggle_en = 1; src_sel = 2'b10; step(2);
    go_set = 1; step(2);
    meas_cnt = 0; ev_cnt = 0;
    for (int k = 0; k < 4; k++) begin
      match_pulse = 1; step(1); match_pulse = 0; step(8);
    end
    step(3);
    chk_int(meas_cnt, 9, "R9 full period count");
    chk_int(ev_cnt, 1, "R11 single event for period");
    // R5 toggle without single: count half the cycles
    single_en = 0; step(2); meas_cnt = 0;
    for (int k = 0; k < 4; k++) begin
      match_pulse = 1; step(1); match_pulse = 0; step(5);
    end
    chk_int(meas_cnt, 12, "R5 toggle duty count");
    toggle_en = 0; step(1);
    #1 chk(gate_level, 1'b0, "R6 toggle cleared");
    meas_on = 0;

    // random mix compared by the model every cycle
    for (int c = 0; c < 6000; c++) begin
      if (c % 97 == 0) begin
        gate_en = 1'($urandom); src_sel = 2'($urandom); invert = 1'($urandom);
        toggle_en = 1'($urandom); single_en = 1'($urandom % 4 != 0);
      end
      gate_pin = ($urandom % 5 == 0) ? ~gate_pin : gate_pin;
      ovf8_pulse = ($urandom % 11 == 0);
      match_pulse = ($urandom % 7 == 0);
      spare_in = ($urandom % 4 == 0) ? ~spare_in : spare_in;
      go_set = ($urandom % 13 == 0);
      @(posedge clk); #1;
    end
    cmp_on = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule